// File: doc/BRIEF.md
# Accelerometer Output Register Front-End

This block sits between a three-axis sample source and a host register port. It holds the control fields that the host writes: power state, output rate, per-axis enables, self-test, full-scale range, a freeze mode for coherent byte reads, byte order, and the source for the ready pin. It divides the system clock into a sample strobe at one of four rates. On each strobe it captures the 16-bit value of every enabled axis into an output register. It returns those registers one byte per address, in the byte order that the host selects.

The host port uses a plain address and write-data pair with a write enable and a read strobe. Read data is combinational from the address while the read strobe is high. Reads of axis bytes have side effects: they complete a byte pair, clear data-ready, and release a frozen axis. The strobe, the full-scale bit and the self-test bit are outputs towards the sample source.

Top module: `accel_out_regs`

## Requirements
- R1: After reset, control register A (address 0x00) reads 0xE0. Its layout is bits [1:0] power, [3:2] rate, 4 self-test, 5 X enable, 6 Y enable, 7 Z enable. Control register B (address 0x01) reads 0x00. Its layout is bit 0 full-scale, 1 freeze, 2 big-endian, 3 ready-source, 4 data-ready enable. All axis byte addresses 0x02 to 0x07 read 0x00, and ready is 0.
- R2: While the power field is 00, no sample strobe is issued and the axis output registers keep their values. Any nonzero power code enables strobes.
- R3: The strobe period is CLK_HZ/(40·4^code) clock cycles for rate code 0 to 3 (40, 160, 640, 2560 Hz). A write that changes the rate code restarts the count, so the first strobe comes term−1 cycles after the write edge.
- R4: On a strobe, each axis whose enable bit is 1 captures its input sample. An axis whose enable bit is 0 keeps its previous value.
- R5: Addresses 0x02/0x03 hold X, 0x04/0x05 hold Y and 0x06/0x07 hold Z. With big-endian 0, the lower address returns the low byte. With big-endian 1, the lower address returns the high byte.
- R6: With freeze set, an axis whose first byte has been read keeps its value until its other byte is read. A sample that arrives in between is held aside and appears after that second read.
- R7: With freeze clear, an axis register updates on every strobe, even between the two byte reads.
- R8: When data-ready is enabled, a strobe sets data-ready on the next cycle. The second byte read of any axis clears it.
- R9: With the data-ready enable bit 0, data-ready stays 0.
- R10: With ready-source 0, the ready pin carries data-ready. With ready-source 1, it carries the intEvent input.
- R11: The fullScale and selfTest outputs follow their control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe (side effects on axis bytes) |
| rdData | output | 8 | Read data for addr |
| sampleX | input | 16 | X-axis sample from source |
| sampleY | input | 16 | Y-axis sample from source |
| sampleZ | input | 16 | Z-axis sample from source |
| sampleTick | output | 1 | Sample strobe; samples captured on this cycle |
| fullScale | output | 1 | Range select to source (0 ±2g, 1 ±6g) |
| selfTest | output | 1 | Self-test request to source |
| intEvent | input | 1 | Interrupt event from external detectors |
| ready | output | 1 | Ready pin |

## Verification
The bench targets freeze mode across a strobe. A design that ignores the freeze would return a high byte that does not match the low byte already read. A design that loses the held sample would return the stale value after the pair completes. The bench also measures the strobe spacing after a rate write, which catches a counter that is not restarted or that is off by one. It checks that a disabled axis and a powered-down block both leave old data in place. It checks that byte order swaps at the address level and not only in one byte.

// File: rtl/accel_regs_pkg.sv
package accel_regs_pkg;
  localparam int AXES = 3;
  localparam int SAMPLE_W = 16;

  typedef struct packed {
    logic [1:0] power;
    logic [1:0] rate;
    logic       selfTest;
    logic       xEn;
    logic       yEn;
    logic       zEn;
    logic       fullScale;
    logic       freeze;
    logic       bigEndian;
    logic       intSel;
    logic       drdyEn;
  } cfg_t;

  typedef struct packed {
    logic       tick;
    logic       rdAxisHit;
    logic [1:0] rdAxis;
  } strobe_t;
endpackage

// File: rtl/accel_ctrl.sv
module accel_ctrl
  import accel_regs_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int AW = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [AW-1:0]                    addr,
  input  logic [7:0]                       wrData,
  input  logic                             rdEn,
  input  logic [AXES-1:0][SAMPLE_W-1:0]    axisOut,
  output cfg_t                             cfg,
  output strobe_t                          strb,
  output logic [7:0]                       rdData
);
  localparam int unsigned TERM [4] = '{CLK_HZ/40, CLK_HZ/160, CLK_HZ/640, CLK_HZ/2560};
  localparam int CNT_W = $clog2(CLK_HZ/40 + 1);
  localparam logic [AW-1:0] A_CTRL_A = AW'(0);
  localparam logic [AW-1:0] A_CTRL_B = AW'(1);
  localparam logic [AW-1:0] A_AXIS_LO = AW'(2);
  localparam logic [AW-1:0] A_AXIS_HI = AW'(7);

  logic [CNT_W-1:0] cnt;
  logic             rateChg, tickNow, axisAddr, hiSel;
  logic [AW-1:0]    offs;
  logic [1:0]       axisIdx;
  logic [SAMPLE_W-1:0] selWord;

  assign rateChg = wrEn && (addr == A_CTRL_A) && (wrData[3:2] != cfg.rate);
  assign tickNow = (cfg.power != 2'b00) && (cnt == CNT_W'(TERM[cfg.rate] - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '{power: 2'b00, rate: 2'b00, selfTest: 1'b0, xEn: 1'b1, yEn: 1'b1,
               zEn: 1'b1, fullScale: 1'b0, freeze: 1'b0, bigEndian: 1'b0,
               intSel: 1'b0, drdyEn: 1'b0};
    end else if (wrEn && addr == A_CTRL_A) begin
      cfg.power    <= wrData[1:0];
      cfg.rate     <= wrData[3:2];
      cfg.selfTest <= wrData[4];
      cfg.xEn      <= wrData[5];
      cfg.yEn      <= wrData[6];
      cfg.zEn      <= wrData[7];
    end else if (wrEn && addr == A_CTRL_B) begin
      cfg.fullScale <= wrData[0];
      cfg.freeze    <= wrData[1];
      cfg.bigEndian <= wrData[2];
      cfg.intSel    <= wrData[3];
      cfg.drdyEn    <= wrData[4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || cfg.power == 2'b00 || rateChg || tickNow) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign axisAddr = (addr >= A_AXIS_LO) && (addr <= A_AXIS_HI);
  assign offs     = addr - A_AXIS_LO;
  assign axisIdx  = offs[2:1];
  assign hiSel    = addr[0] ^ cfg.bigEndian;
  assign selWord  = (axisIdx < 2'(AXES)) ? axisOut[axisIdx] : '0;

  assign strb.tick      = tickNow;
  assign strb.rdAxisHit = rdEn && axisAddr;
  assign strb.rdAxis    = axisIdx;

  always_comb begin
    rdData = '0;
    if (addr == A_CTRL_A)
      rdData = {cfg.zEn, cfg.yEn, cfg.xEn, cfg.selfTest, cfg.rate, cfg.power};
    else if (addr == A_CTRL_B)
      rdData = {3'b000, cfg.drdyEn, cfg.intSel, cfg.bigEndian, cfg.freeze, cfg.fullScale};
    else if (axisAddr)
      rdData = hiSel ? selWord[15:8] : selWord[7:0];
  end
endmodule

// File: rtl/accel_datapath.sv
module accel_datapath
  import accel_regs_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  cfg_t                          cfg,
  input  strobe_t                       strb,
  input  logic [AXES-1:0][SAMPLE_W-1:0] sampleIn,
  output logic [AXES-1:0][SAMPLE_W-1:0] axisOut,
  output logic [AXES-1:0]               halfRead,
  output logic                          drdy
);
  logic [AXES-1:0] axisEn, secondRd;

  assign axisEn = {cfg.zEn, cfg.yEn, cfg.xEn};

  for (genvar i = 0; i < AXES; i++) begin : g_axis
    logic [SAMPLE_W-1:0] outR, shadowR;
    logic halfR, pendR, rdThis, frozen;

    assign rdThis      = strb.rdAxisHit && (strb.rdAxis == 2'(i));
    assign secondRd[i] = rdThis && halfR;
    assign frozen      = cfg.freeze && halfR && !secondRd[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outR <= '0; shadowR <= '0; halfR <= 1'b0; pendR <= 1'b0;
      end else begin
        if (rdThis) halfR <= !halfR;
        if (strb.tick && axisEn[i]) begin
          if (frozen) begin
            shadowR <= sampleIn[i];
            pendR   <= 1'b1;
          end else begin
            outR  <= sampleIn[i];
            pendR <= 1'b0;
          end
        end else if (secondRd[i] && pendR) begin
          outR  <= shadowR;
          pendR <= 1'b0;
        end
      end
    end

    assign axisOut[i]  = outR;
    assign halfRead[i] = halfR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) drdy <= 1'b0;
    else if (strb.tick && cfg.drdyEn) drdy <= 1'b1;
    else if (!cfg.drdyEn || |secondRd) drdy <= 1'b0;
  end
endmodule

// File: rtl/accel_out_regs.sv
module accel_out_regs
  import accel_regs_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  addr,
  input  logic [7:0]  wrData,
  input  logic        rdEn,
  output logic [7:0]  rdData,
  input  logic [15:0] sampleX,
  input  logic [15:0] sampleY,
  input  logic [15:0] sampleZ,
  output logic        sampleTick,
  output logic        fullScale,
  output logic        selfTest,
  input  logic        intEvent,
  output logic        ready
);
  cfg_t    cfg;
  strobe_t strb;
  logic [AXES-1:0][SAMPLE_W-1:0] axisOut;
  logic [AXES-1:0]               halfRead;
  logic                          drdy;

  accel_ctrl #(.CLK_HZ(CLK_HZ), .AW(8)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdEn(rdEn), .axisOut(axisOut), .cfg(cfg), .strb(strb), .rdData(rdData)
  );

  accel_datapath uData (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb),
    .sampleIn({sampleZ, sampleY, sampleX}), .axisOut(axisOut),
    .halfRead(halfRead), .drdy(drdy)
  );

  assign sampleTick = strb.tick;
  assign fullScale  = cfg.fullScale;
  assign selfTest   = cfg.selfTest;
  assign ready      = cfg.intSel ? intEvent : drdy;
endmodule

// File: rtl/accel_out_regs_chk.sv
module accel_out_regs_chk
  import accel_regs_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input cfg_t                          cfg,
  input strobe_t                       strb,
  input logic [AXES-1:0][SAMPLE_W-1:0] axisOut,
  input logic [AXES-1:0]               halfRead,
  input logic                          drdy
);
  logic [AXES-1:0] axisEn;
  assign axisEn = {cfg.zEn, cfg.yEn, cfg.xEn};

  p_powerdown_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.power == 2'b00) |-> !strb.tick);

  p_powerdown_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.power == 2'b00 && !strb.rdAxisHit) |=> $stable(axisOut));

  for (genvar i = 0; i < AXES; i++) begin : g_chk
    p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      (!axisEn[i] && !strb.rdAxisHit) |=> $stable(axisOut[i]));

    p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (cfg.freeze && halfRead[i] && !strb.rdAxisHit) |=> $stable(axisOut[i]));
  end

  p_drdy_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && cfg.drdyEn) |=> drdy);

  p_drdy_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.drdyEn |=> !drdy);
endmodule

bind accel_out_regs accel_out_regs_chk uChk (
  .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb),
  .axisOut(axisOut), .halfRead(halfRead), .drdy(drdy)
);

// File: tb/tb_accel_out_regs.sv
module tb_accel_out_regs;
  localparam int unsigned CLK_HZ = 128_000;   // terms: 3200, 800, 200, 50

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, intEvent = 1'b0;
  logic [7:0] addr = '0, wrData = '0, rdData;
  logic [15:0] sampleX = '0, sampleY = '0, sampleZ = '0;
  logic sampleTick, fullScale, selfTest, ready;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  accel_out_regs #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .sampleX(sampleX), .sampleY(sampleY),
    .sampleZ(sampleZ), .sampleTick(sampleTick), .fullScale(fullScale),
    .selfTest(selfTest), .intEvent(intEvent), .ready(ready)
  );

  // {address, expected read} after reset
  localparam logic [15:0] RESET_VEC [8] = '{
    16'h00E0, 16'h0100, 16'h0200, 16'h0300,
    16'h0400, 16'h0500, 16'h0600, 16'h0700
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a; rdEn = 1'b1;
    #2 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    rd(a, v);
    check(v == e, req, v, e);
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!sampleTick);
    @(negedge clk);
  endtask

  task automatic gapCount(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sampleTick && n < 10000);
  endtask

  initial begin
    int n;
    int ticksSeen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, walked from the table
    for (int i = 0; i < 8; i++) rdChk(RESET_VEC[i][15:8], RESET_VEC[i][7:0], "R1");
    check(ready == 1'b0, "R1 ready", ready, 0);

    // R2 power-down: no strobes
    ticksSeen = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (sampleTick) ticksSeen++; end
    check(ticksSeen == 0, "R2 no tick", ticksSeen, 0);

    // power on, rate 3, data-ready on, little endian
    sampleX = 16'h1234; sampleY = 16'h5678; sampleZ = 16'h9ABC;
    wr(8'h01, 8'h10);
    wr(8'h00, 8'hED);
    do @(negedge clk); while (!sampleTick);
    gapCount(n);
    check(n == 50, "R3 period rate3", n, 50);
    @(negedge clk);
    check(ready == 1'b1, "R8 ready set", ready, 1);
    rdChk(8'h02, 8'h34, "R5 X low LE");
    rdChk(8'h03, 8'h12, "R5 X high LE");
    check(ready == 1'b0, "R8 ready cleared", ready, 0);
    rdChk(8'h04, 8'h78, "R4 Y low");
    rdChk(8'h05, 8'h56, "R4 Y high");

    // R4 disabled X axis holds
    wr(8'h00, 8'hCD);
    sampleX = 16'hAAAA; sampleY = 16'h4444;
    waitTick();
    rdChk(8'h02, 8'h34, "R4 X held low");
    rdChk(8'h03, 8'h12, "R4 X held high");
    wr(8'h00, 8'hED);

    // R7 freeze off: Y updates between byte reads
    waitTick();
    rdChk(8'h04, 8'h44, "R7 Y low");
    sampleY = 16'h5566;
    waitTick();
    rdChk(8'h05, 8'h55, "R7 Y high new");

    // R6 freeze on
    wr(8'h01, 8'h12);
    sampleZ = 16'h1111;
    waitTick();
    rdChk(8'h06, 8'h11, "R6 Z low");
    sampleZ = 16'h2233;
    waitTick();
    rdChk(8'h07, 8'h11, "R6 Z high frozen");
    rdChk(8'h06, 8'h33, "R6 Z low released");
    rdChk(8'h07, 8'h22, "R6 Z high released");

    // R5 big endian
    wr(8'h01, 8'h14);
    rdChk(8'h04, 8'h55, "R5 Y low addr BE");
    rdChk(8'h05, 8'h66, "R5 Y high addr BE");
    rdChk(8'h02, 8'hAA, "R5 X low addr BE");
    rdChk(8'h03, 8'hAA, "R5 X high addr BE");
    wr(8'h01, 8'h10);

    // R2 power-down holds values and stops strobes
    wr(8'h00, 8'hEC);
    sampleZ = 16'h7777;
    ticksSeen = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (sampleTick) ticksSeen++; end
    check(ticksSeen == 0, "R2 no tick off", ticksSeen, 0);
    rdChk(8'h06, 8'h33, "R2 Z held low");
    rdChk(8'h07, 8'h22, "R2 Z held high");
    wr(8'h00, 8'hED);

    // R9 data-ready disabled
    wr(8'h01, 8'h00);
    waitTick();
    check(ready == 1'b0, "R9 ready stays low", ready, 0);

    // R10 ready source
    wr(8'h01, 8'h08);
    intEvent = 1'b1; #1;
    check(ready == 1'b1, "R10 int high", ready, 1);
    intEvent = 1'b0; #1;
    check(ready == 1'b0, "R10 int low", ready, 0);

    // R11 outputs mirror bits
    wr(8'h01, 8'h01);
    wr(8'h00, 8'hFD);
    check(fullScale == 1'b1, "R11 fullScale", fullScale, 1);
    check(selfTest == 1'b1, "R11 selfTest", selfTest, 1);
    rdChk(8'h00, 8'hFD, "R11 ctrl A readback");
    rdChk(8'h01, 8'h01, "R11 ctrl B readback");

    // R3 rate change restarts counter, then period
    wr(8'h00, 8'hE9);
    gapCount(n);
    check(n == 199, "R3 restart", n, 199);
    gapCount(n);
    check(n == 200, "R3 period rate2", n, 200);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule